// File: doc/BRIEF.md
# Four-Phase Control-Register Port Master

This block drives the internal control-register port of a PHY on behalf of a local requester. The port carries a 16-bit address and 16-bit data. The master sends both over one shared 16-bit outbound bus. Four separate strobes qualify that bus: capture-address, capture-data, write and read. The slave answers on a single acknowledge line and a 16-bit inbound data bus.

Every step of an access is a full four-phase handshake:

1. Raise one strobe.
2. Wait for the acknowledge to go high.
3. Drop the strobe.
4. Wait for the acknowledge to go low.

A write uses three such handshakes: address capture, data capture and commit. A read uses two: address capture, then the read strobe. The inbound data is latched at the moment the acknowledge rises during the read handshake.

Each wait on the acknowledge line has a bounded cycle budget. If the budget runs out, the access is abandoned, every strobe is released and an error pulse is reported. Requests are taken one at a time, and only while the master is idle.

Top module: `crpm_master`

## Requirements
- R1: While reset is asserted and right after its release, all four strobes, `busy`, `done`, `error`, `cr_din` and `rd_data` are zero.
- R2: At most one of `cr_cap_addr`, `cr_cap_data`, `cr_write`, `cr_read` is high in any cycle.
- R3: A write places the address on `cr_din` under `cr_cap_addr`, then the write data under `cr_cap_data`, then raises `cr_write`. A later read of the same address returns the written value.
- R4: A read places the address under `cr_cap_addr`, then raises `cr_read`. It captures `cr_dout` in the cycle the acknowledge is first seen high, and presents that value on `rd_data` when `done` pulses.
- R5: A strobe stays high with `cr_din` held stable until the acknowledge is seen high. The next strobe is raised only after the acknowledge is seen low.
- R6: With a slave whose acknowledge follows the strobes one cycle later, `done` rises 12 clock edges after a write is accepted and 8 edges after a read is accepted.
- R7: If the acknowledge does not rise within `POLL_LIMIT` cycles of a wait starting, `error` pulses `POLL_LIMIT` edges after that start. All strobes drop, `done` stays low and the master returns to idle.
- R8: If the acknowledge stays high past `POLL_LIMIT` cycles in a wait-for-low, the access also ends with `error`. With the one-cycle slave and the stall in the first wait-for-low, `error` arrives `POLL_LIMIT`+2 edges after acceptance.
- R9: `done` and `error` are single-cycle pulses and never high together.
- R10: A request presented while `busy` is high is ignored. It causes no extra `done` and no slave write.
- R11: `rd_data` keeps the last read value through later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on acknowledge timeout |
| rd_data | output | 16 | Last data read |
| cr_din | output | 16 | Shared address/data bus to the slave |
| cr_cap_addr | output | 1 | Capture-address strobe |
| cr_cap_data | output | 1 | Capture-data strobe |
| cr_write | output | 1 | Commit-write strobe |
| cr_read | output | 1 | Read strobe |
| cr_ack | input | 1 | Slave acknowledge |
| cr_dout | input | 16 | Slave read data |

## Verification
Each handshake costs 2D+2 edges for a slave delay D. With the bench slave at D=1, `done` is due 12 edges after a write is accepted and 8 after a read. A timeout lands exactly `POLL_LIMIT` edges after the wait begins. The bench counts edges from the accepting edge to the first sampled pulse of `done` or `error`, and compares that count with these figures. All sampling happens on the falling edge, so every registered result has settled.

// File: rtl/crpm_pkg.sv
package crpm_pkg;
  localparam int unsigned CR_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_ADR_UP = 4'd1,
    ST_ADR_DN = 4'd2,
    ST_DAT_UP = 4'd3,
    ST_DAT_DN = 4'd4,
    ST_WR_UP  = 4'd5,
    ST_WR_DN  = 4'd6,
    ST_RD_UP  = 4'd7,
    ST_RD_DN  = 4'd8
  } crpm_state_e;
endpackage

// File: rtl/crpm_poll_timer.sv
module crpm_poll_timer #(
  parameter int unsigned POLL_LIMIT = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign expired = run && (cnt_q == LAST);

  always_comb begin
    cnt_en = clear || run;
    if (clear) cnt_n = '0;
    else       cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/crpm_seq.sv
module crpm_seq
  import crpm_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        ack,
  output crpm_state_e state,
  output logic        load_addr,
  output logic        load_data,
  output logic        cap_rdata,
  output logic        done,
  output logic        error
);
  crpm_state_e st_q, st_n;
  logic        wr_q;
  logic        wait_hi, wait_lo, waiting, timeout;
  logic        fin_ok;

  assign state   = st_q;
  assign wait_hi = (st_q == ST_ADR_UP) || (st_q == ST_DAT_UP) ||
                   (st_q == ST_WR_UP)  || (st_q == ST_RD_UP);
  assign wait_lo = (st_q == ST_ADR_DN) || (st_q == ST_DAT_DN) ||
                   (st_q == ST_WR_DN)  || (st_q == ST_RD_DN);
  assign waiting = (wait_hi && !ack) || (wait_lo && ack);

  crpm_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (st_n != st_q),
    .run     (waiting),
    .expired (timeout)
  );

  always_comb begin
    st_n      = st_q;
    load_addr = 1'b0;
    load_data = 1'b0;
    cap_rdata = 1'b0;
    fin_ok    = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        st_n      = ST_ADR_UP;
        load_addr = 1'b1;
      end
      ST_ADR_UP: if (ack) st_n = ST_ADR_DN;
      ST_ADR_DN: if (!ack) begin
        if (wr_q) begin
          st_n      = ST_DAT_UP;
          load_data = 1'b1;
        end else begin
          st_n = ST_RD_UP;
        end
      end
      ST_DAT_UP: if (ack) st_n = ST_DAT_DN;
      ST_DAT_DN: if (!ack) st_n = ST_WR_UP;
      ST_WR_UP:  if (ack) st_n = ST_WR_DN;
      ST_WR_DN: if (!ack) begin
        st_n   = ST_IDLE;
        fin_ok = 1'b1;
      end
      ST_RD_UP: if (ack) begin
        st_n      = ST_RD_DN;
        cap_rdata = 1'b1;
      end
      ST_RD_DN: if (!ack) begin
        st_n   = ST_IDLE;
        fin_ok = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
    if (timeout) begin
      st_n      = ST_IDLE;
      load_data = 1'b0;
      cap_rdata = 1'b0;
      fin_ok    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      wr_q  <= 1'b0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      st_q  <= st_n;
      done  <= fin_ok;
      error <= timeout;
      if (load_addr) wr_q <= req_write;
    end
  end
endmodule

// File: rtl/crpm_bus_regs.sv
module crpm_bus_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_addr,
  input  logic         load_data,
  input  logic         cap_rdata,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] dout,
  output logic [W-1:0] din,
  output logic [W-1:0] rdata
);
  logic [W-1:0] din_q, din_n, wd_q, rd_q;
  logic         din_en;

  assign din    = din_q;
  assign rdata  = rd_q;
  assign din_en = load_addr || load_data;

  always_comb begin
    if (load_addr) din_n = addr;
    else           din_n = wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (din_en)    din_q <= din_n;
      if (load_addr) wd_q  <= wdata;
      if (cap_rdata) rd_q  <= dout;
    end
  end
endmodule

// File: rtl/crpm_master.sv
module crpm_master
  import crpm_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 500000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [CR_W-1:0] req_addr,
  input  logic [CR_W-1:0] req_wdata,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic [CR_W-1:0] rd_data,
  output logic [CR_W-1:0] cr_din,
  output logic            cr_cap_addr,
  output logic            cr_cap_data,
  output logic            cr_write,
  output logic            cr_read,
  input  logic            cr_ack,
  input  logic [CR_W-1:0] cr_dout
);
  crpm_state_e st;
  logic        ld_addr, ld_data, cap_rd;

  crpm_seq #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .ack       (cr_ack),
    .state     (st),
    .load_addr (ld_addr),
    .load_data (ld_data),
    .cap_rdata (cap_rd),
    .done      (done),
    .error     (error)
  );

  crpm_bus_regs #(.W(CR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_addr (ld_addr),
    .load_data (ld_data),
    .cap_rdata (cap_rd),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .dout      (cr_dout),
    .din       (cr_din),
    .rdata     (rd_data)
  );

  assign busy        = (st != ST_IDLE);
  assign cr_cap_addr = (st == ST_ADR_UP);
  assign cr_cap_data = (st == ST_DAT_UP);
  assign cr_write    = (st == ST_WR_UP);
  assign cr_read     = (st == ST_RD_UP);
endmodule

// File: rtl/crpm_master_chk.sv
module crpm_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cr_cap_addr,
  input logic        cr_cap_data,
  input logic        cr_write,
  input logic        cr_read,
  input logic        cr_ack,
  input logic [15:0] cr_din,
  input logic        done,
  input logic        error
);
  logic [3:0] stb;
  assign stb = {cr_read, cr_write, cr_cap_data, cr_cap_addr};

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stb) <= 1); // R2

  AST_DIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stb != 4'd0) && $past(stb) == stb) |-> $stable(cr_din)); // R5

  AST_ADDR_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cr_cap_addr) && !error) |-> $past(cr_ack)); // R5

  AST_WRITE_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cr_write) && !error) |-> $past(cr_ack)); // R5

  AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (stb == 4'd0) && !done); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error); // R9
endmodule

bind crpm_master crpm_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cr_cap_addr (cr_cap_addr),
  .cr_cap_data (cr_cap_data),
  .cr_write    (cr_write),
  .cr_read     (cr_read),
  .cr_ack      (cr_ack),
  .cr_din      (cr_din),
  .done        (done),
  .error       (error)
);

// File: tb/crpm_master_tb.sv
module crpm_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        busy, done, error;
  logic [15:0] rd_data, cr_din, cr_dout;
  logic        cr_cap_addr, cr_cap_data, cr_write, cr_read, cr_ack;

  int checks = 0, errors = 0;
  int mode = 0; // 0 normal, 1 never ack, 2 ack stuck high

  always #(CLK_PERIOD/2) clk = ~clk;

  crpm_master #(.POLL_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .error(error), .rd_data(rd_data), .cr_din(cr_din),
    .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
    .cr_write(cr_write), .cr_read(cr_read), .cr_ack(cr_ack),
    .cr_dout(cr_dout));

  // Slave model: acknowledge follows the strobes one cycle later.
  logic [15:0] s_addr, s_data;
  logic [15:0] mem [16];
  logic        any_stb;
  assign any_stb = cr_cap_addr | cr_cap_data | cr_write | cr_read;
  assign cr_dout = mem[s_addr[3:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_ack <= 1'b0;
      s_addr <= '0;
      s_data <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      if (mode == 1)      cr_ack <= 1'b0;
      else if (mode == 2) cr_ack <= cr_ack | any_stb;
      else                cr_ack <= any_stb;
      if (cr_cap_addr && !cr_ack) s_addr <= cr_din;
      if (cr_cap_data && !cr_ack) s_data <= cr_din;
      if (cr_write && !cr_ack)    mem[s_addr[3:0]] <= s_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Issue one request; lat = edges from accepting edge to first result pulse.
  task automatic run_req(input bit w, input logic [15:0] a, input logic [15:0] d,
                         output int lat, output bit got_done, output bit got_err);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_done = 1'b0; got_err = 1'b0;
    n = 1;
    while (!done && !error && n < 300) begin
      @(negedge clk);
      n++;
    end
    got_done = done; got_err = error;
    lat = n - 1;
  endtask

  localparam logic [48:0] VEC [8] = '{
    {1'b1, 16'h0001, 16'hA5A5, 16'h0000},
    {1'b1, 16'h0002, 16'h1234, 16'h0000},
    {1'b1, 16'h000F, 16'hFFFF, 16'h0000},
    {1'b1, 16'h0000, 16'h8001, 16'h0000},
    {1'b0, 16'h0002, 16'h0000, 16'h1234},
    {1'b0, 16'h0001, 16'h0000, 16'hA5A5},
    {1'b0, 16'h000F, 16'h0000, 16'hFFFF},
    {1'b0, 16'h0000, 16'h0000, 16'h8001}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    bit gd, ge;
    int ndone;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({cr_cap_addr, cr_cap_data, cr_write, cr_read, busy, done, error} == 7'd0,
          "R1 outputs in reset", 0, 0);
    check(cr_din == 16'h0 && rd_data == 16'h0, "R1 buses in reset", cr_din, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !error && !cr_cap_addr, "R1 after release", busy, 0);

    // R3 R4 R6: vector table
    foreach (VEC[i]) begin
      run_req(VEC[i][48], VEC[i][47:32], VEC[i][31:16], lat, gd, ge);
      check(gd && !ge, VEC[i][48] ? "R3 write done" : "R4 read done", gd, 1);
      check(lat == (VEC[i][48] ? 12 : 8), "R6 latency", lat, VEC[i][48] ? 12 : 8);
      if (!VEC[i][48])
        check(rd_data == VEC[i][15:0], "R4 R3 read data", rd_data, VEC[i][15:0]);
      @(negedge clk);
      check(!done && !error, "R9 single-cycle pulse", done, 0);
    end

    // R11: rd_data persists over a write
    run_req(1'b1, 16'h0003, 16'h5555, lat, gd, ge);
    check(rd_data == 16'h8001, "R11 rd_data held", rd_data, 16'h8001);

    // R10: request during busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0005; req_wdata = 16'h7777;
    @(posedge clk);
    @(negedge clk);
    req_addr = 16'h0006; req_wdata = 16'h9999;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    ndone = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (done) ndone++;
    end
    check(ndone == 1, "R10 one done only", ndone, 1);
    run_req(1'b0, 16'h0006, 16'h0, lat, gd, ge);
    check(rd_data == 16'h0000, "R10 no stray write", rd_data, 0);
    run_req(1'b0, 16'h0005, 16'h0, lat, gd, ge);
    check(rd_data == 16'h7777, "R10 first request kept", rd_data, 16'h7777);

    // R7: acknowledge never rises
    mode = 1;
    run_req(1'b1, 16'h0004, 16'h4444, lat, gd, ge);
    check(ge && !gd, "R7 timeout error", ge, 1);
    check(lat == LIMIT, "R7 timeout latency", lat, LIMIT);
    check(!busy && !cr_cap_addr, "R7 released to idle", busy, 0);
    @(negedge clk);
    check(!error, "R9 error pulse", error, 0);

    // R8: acknowledge stuck high
    mode = 2;
    run_req(1'b0, 16'h0001, 16'h0, lat, gd, ge);
    check(ge && !gd, "R8 stuck-high error", ge, 1);
    check(lat == LIMIT + 2, "R8 latency", lat, LIMIT + 2);
    check(rd_data == 16'h7777, "R8 rd_data untouched", rd_data, 16'h7777);

    // recovery
    mode = 0;
    repeat (3) @(negedge clk);
    run_req(1'b0, 16'h0002, 16'h0, lat, gd, ge);
    check(gd && rd_data == 16'h1234, "R4 read after recovery", rd_data, 16'h1234);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule